// File: doc/BRIEF.md
# Width-Converting Byte FIFO with Selectable Lane Order

This block is the small elastic store inside one DMA channel, between the side that reads from the source and the side that writes to the destination. The source side pushes beats of one, two or four bytes; the destination side asks for beats of one, two or four bytes, and the two sizes need not match. Inside, the data is kept as an ordered stream of bytes, so a byte stream written as words can be taken out as halfwords or single bytes, and the reverse, without any byte changing place in address order.

How the bytes of a beat map onto its data lanes is set by an endian select. In little-endian order the first byte of a beat sits in the lowest lane; in big-endian order it sits in the highest lane the beat uses. The select is taken into the block only while it holds no data, so bytes already stored are always read back with the order they were written in. The lane order register comes out of reset as little-endian. At the end of a transfer a flush input lets the reader drain a remainder smaller than the beat it asks for.

Top module: `pk_width_fifo`

## Requirements
- R1: After reset the block is empty: `level` is 0, `rd_valid` is 0 and `wr_ready` is 1.
- R2: Size codes on `wr_size` and `rd_size` are 0 for one byte, 1 for two bytes and 2 for four bytes; code 3 is reserved and is not driven.
- R3: `wr_ready` is 1 exactly when the free space (16 minus `level`) is at least the byte count of `wr_size`; `level` never exceeds 16.
- R4: Without flush, `rd_valid` is 1 exactly when `level` is at least the byte count of `rd_size`, and then `rd_count` equals that byte count.
- R5: In little-endian order, byte k of a beat (k=0 first in address order) occupies bits 8k+7:8k, on both ports, so bytes leave in the order they entered whatever the two widths.
- R6: In big-endian order, byte k of an N-byte beat occupies bits 8(N-1-k)+7:8(N-1-k), on both ports.
- R7: With `flush` at 1 and 0 < `level` < requested byte count, `rd_valid` is 1, `rd_count` equals `level`, and the held bytes take the lanes of a beat of the requested size in the active order, with missing lanes zero.
- R8: A change on `endian_be` while `level` is nonzero has no effect on data written or read; the new order applies from the first cycle in which `level` is 0.
- R9: A write and a read may complete in the same cycle; after each edge `level` equals its old value plus the bytes written minus the bytes read.
- R10: Write lanes above the beat size are ignored, and read lanes outside the returned bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| endian_be | input | 1 | 1 selects big-endian lane order, sampled while empty |
| flush | input | 1 | End of transfer: lets a short remainder be read |
| wr_valid | input | 1 | Write beat offered |
| wr_size | input | 2 | Write beat size code |
| wr_data | input | 32 | Write beat data |
| wr_ready | output | 1 | Room for the offered write beat |
| rd_size | input | 2 | Requested read beat size code |
| rd_valid | output | 1 | Read beat available |
| rd_ready | input | 1 | Reader takes the beat |
| rd_data | output | 32 | Read beat data |
| rd_count | output | 3 | Number of bytes in the read beat |
| level | output | 5 | Bytes held |

## Verification
The assertions assume that the size codes stay within the three defined values and that a write or read is only counted when its valid and ready are both high. They also take for granted that a beat accepted by the ring never exceeds the free space and a beat removed never exceeds the bytes held, which the handshake logic guarantees. The stimulus draws sizes only from codes 0 to 2, raises flush and toggles the endian select at random including while data is held, and follows the handshake rule through a byte-queue model that decides every acceptance.

// File: rtl/pk_width_pkg.sv
package pk_width_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } beat_size_e;

  // Byte count of a beat size code (reserved code treated as a word).
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_to_bytes = 3'd1;
      SZ_HALF: size_to_bytes = 3'd2;
      default: size_to_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pk_lane_in.sv
// Turns a write beat into bytes in address order: ord byte k is the k-th byte.
module pk_lane_in #(
  parameter int LANES = 4,
  localparam int SW   = $clog2(LANES),
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic [8*LANES-1:0] beat,
  input  logic [NW-1:0]      nbytes,
  input  logic               be,
  output logic [8*LANES-1:0] ord
);

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [SW-1:0] sel;
    always_comb begin
      if (be) sel = SW'(nbytes - NW'(k) - NW'(1));
      else    sel = SW'(k);
      if (NW'(k) < nbytes) ord[8*k +: 8] = beat[{sel, 3'b000} +: 8];
      else                 ord[8*k +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/pk_lane_out.sv
// Places ordered bytes onto the lanes of a beat of nlanes lanes, nvalid filled.
module pk_lane_out #(
  parameter int LANES = 4,
  localparam int SW   = $clog2(LANES),
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic [8*LANES-1:0] ord,
  input  logic [NW-1:0]      nlanes,
  input  logic [NW-1:0]      nvalid,
  input  logic               be,
  output logic [8*LANES-1:0] beat
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NW-1:0] idx;
    always_comb begin
      if (be) idx = nlanes - NW'(l) - NW'(1);
      else    idx = NW'(l);
      if ((NW'(l) < nlanes) && (idx < nvalid))
        beat[8*l +: 8] = ord[{idx[SW-1:0], 3'b000} +: 8];
      else
        beat[8*l +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/pk_byte_ring.sv
// Circular byte store with multi-byte push and pop per cycle.
module pk_byte_ring #(
  parameter int CAP   = 16,
  parameter int LANES = 4,
  localparam int PW   = $clog2(CAP),
  localparam int LW   = $clog2(CAP + 1),
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic [NW-1:0]      push_n,
  input  logic [8*LANES-1:0] push_bytes,
  input  logic               pop_en,
  input  logic [NW-1:0]      pop_n,
  output logic [8*LANES-1:0] head_bytes,
  output logic [LW-1:0]      level
);

  logic [7:0]    mem [CAP];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q,  level_d;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int unsigned k);
    logic [PW:0] s;
    s = {1'b0, p} + (PW+1)'(k);
    if (s >= (PW+1)'(CAP)) s = s - (PW+1)'(CAP);
    return s[PW-1:0];
  endfunction

  // Next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push_en) begin
      wr_ptr_d = wrap_add(wr_ptr_q, int'(push_n));
      level_d  = level_d + LW'(push_n);
    end
    if (pop_en) begin
      rd_ptr_d = wrap_add(rd_ptr_q, int'(pop_n));
      level_d  = level_d - LW'(pop_n);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  // Storage, written only under the push enable
  for (genvar k = 0; k < LANES; k++) begin : g_wr
    always_ff @(posedge clk) begin
      if (push_en && (NW'(k) < push_n))
        mem[wrap_add(wr_ptr_q, k)] <= push_bytes[8*k +: 8];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign head_bytes[8*k +: 8] = mem[wrap_add(rd_ptr_q, k)];
  end

  assign level = level_q;

  // R3: occupancy bound and no push beyond free space
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(CAP));
  a_r3_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (LW'(push_n) <= LW'(CAP) - level_q));
  // R4: never pop more than is held
  a_r4_pop_held: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (LW'(pop_n) <= level_q));
  // R9: no traffic, no change of occupancy
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && !pop_en) |=> $stable(level_q));

endmodule

// File: rtl/pk_width_fifo.sv
module pk_width_fifo
  import pk_width_pkg::*;
#(
  parameter int CAP_WORDS = 4,
  parameter int LANES     = 4,
  localparam int CAP      = CAP_WORDS * LANES,
  localparam int LW       = $clog2(CAP + 1),
  localparam int NW       = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               endian_be,
  input  logic               flush,
  input  logic               wr_valid,
  input  logic [1:0]         wr_size,
  input  logic [8*LANES-1:0] wr_data,
  output logic               wr_ready,
  input  logic [1:0]         rd_size,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [8*LANES-1:0] rd_data,
  output logic [NW-1:0]      rd_count,
  output logic [LW-1:0]      level
);

  logic               be_q, be_d, be_eff;
  logic [NW-1:0]      wr_n, rd_m, rd_n;
  logic               wr_fire, rd_fire, full_beat;
  logic [8*LANES-1:0] wr_ord, head;
  logic [LW-1:0]      lvl;

  // Lane order is only taken in while nothing is stored.
  always_comb begin
    be_eff = (lvl == '0) ? endian_be : be_q;
    be_d   = be_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) be_q <= 1'b0;
    else        be_q <= be_d;
  end

  // Handshake decisions
  always_comb begin
    wr_n      = NW'(size_to_bytes(wr_size));
    rd_m      = NW'(size_to_bytes(rd_size));
    wr_ready  = (LW'(CAP) - lvl) >= LW'(wr_n);
    full_beat = lvl >= LW'(rd_m);
    rd_valid  = full_beat || (flush && (lvl != '0));
    rd_n      = full_beat ? rd_m : NW'(lvl);
    wr_fire   = wr_valid && wr_ready;
    rd_fire   = rd_valid && rd_ready;
  end

  pk_lane_in #(.LANES(LANES)) u_in (
    .beat   (wr_data),
    .nbytes (wr_n),
    .be     (be_eff),
    .ord    (wr_ord)
  );

  pk_byte_ring #(.CAP(CAP), .LANES(LANES)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (wr_fire),
    .push_n     (wr_n),
    .push_bytes (wr_ord),
    .pop_en     (rd_fire),
    .pop_n      (rd_n),
    .head_bytes (head),
    .level      (lvl)
  );

  pk_lane_out #(.LANES(LANES)) u_out (
    .ord    (head),
    .nlanes (rd_m),
    .nvalid (rd_n),
    .be     (be_eff),
    .beat   (rd_data)
  );

  assign rd_count = rd_n;
  assign level    = lvl;

  // R8: stored order frozen while bytes are held
  a_r8_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != '0) |=> $stable(be_q));
  // R7: a short beat is only ever offered under flush
  a_r7_short_needs_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (rd_count < rd_m)) |-> flush);
  // R4: an offered beat carries at least one and at most the requested bytes
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_count != '0) && (rd_count <= rd_m)));
  // R2: size codes stay within the defined set
  a_r2_size_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid |-> (wr_size != SZ_RSVD)) and (rd_ready |-> (rd_size != SZ_RSVD)));

endmodule

// File: tb/pk_width_fifo_test.sv
module pk_width_fifo_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        endian_be, flush, wr_valid, rd_ready;
  logic [1:0]  wr_size, rd_size;
  logic [31:0] wr_data;
  logic        wr_ready, rd_valid;
  logic [31:0] rd_data;
  logic [2:0]  rd_count;
  logic [4:0]  level;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  logic [7:0] q[$];
  logic       mbe = 1'b0;

  logic [31:0] cap_data;
  logic [2:0]  cap_cnt;
  logic        cap_wrdy, cap_rval;
  logic [4:0]  cap_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pk_width_fifo uut (
    .clk(clk), .rst_n(rst_n), .endian_be(endian_be), .flush(flush),
    .wr_valid(wr_valid), .wr_size(wr_size), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_size(rd_size), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_count(rd_count), .level(level)
  );

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check, then update the model at the rising edge.
  task automatic step(input logic wv, input logic [1:0] ws, input logic [31:0] wd,
                      input logic rr, input logic [1:0] rs, input logic fl, input logic be);
    int n_w, m_r, n_r, held;
    logic eff, e_wrdy, e_rval;
    logic [31:0] e_data;
    @(negedge clk);
    wr_valid = wv; wr_size = ws; wr_data = wd;
    rd_ready = rr; rd_size = rs; flush = fl; endian_be = be;
    #1;
    held = q.size();
    eff  = (held == 0) ? be : mbe;
    n_w  = nb(ws);
    m_r  = nb(rs);
    e_wrdy = (16 - held) >= n_w;
    e_rval = (held >= m_r) || (fl && held != 0);
    n_r  = (held >= m_r) ? m_r : held;
    e_data = '0;
    for (int k = 0; k < n_r; k++)
      e_data[8*(eff ? (m_r-1-k) : k) +: 8] = q[k];
    cap_data = rd_data; cap_cnt = rd_count; cap_wrdy = wr_ready;
    cap_rval = rd_valid; cap_lvl = level;
    chk(wr_ready == e_wrdy, "R3 wr_ready", {31'd0, wr_ready}, {31'd0, e_wrdy});
    chk(level == 5'(held), "R9 level", {27'd0, level}, 32'(held));
    chk(rd_valid == e_rval, (held < m_r) ? "R7 rd_valid" : "R4 rd_valid",
        {31'd0, rd_valid}, {31'd0, e_rval});
    if (e_rval && rd_valid) begin
      chk(rd_count == 3'(n_r), (n_r < m_r) ? "R7 rd_count" : "R4 rd_count",
          {29'd0, rd_count}, 32'(n_r));
      chk(rd_data == e_data, (n_r < m_r) ? "R7 rd_data" : (eff ? "R6 rd_data" : "R5 rd_data"),
          rd_data, e_data);
    end
    @(posedge clk);
    mbe = eff;
    if (rr && e_rval)
      for (int k = 0; k < n_r; k++) void'(q.pop_front());
    if (wv && e_wrdy)
      for (int k = 0; k < n_w; k++)
        q.push_back(wd[8*(eff ? (n_w-1-k) : k) +: 8]);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; endian_be = 0; flush = 0; wr_valid = 0; rd_ready = 0;
    wr_size = 0; rd_size = 0; wr_data = '0;
    void'($urandom(32'd715));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(level == 5'd0, "R1 level", {27'd0, level}, 32'd0);
    chk(rd_valid == 1'b0, "R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk(wr_ready == 1'b1, "R1 wr_ready", {31'd0, wr_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: word in, byte and half out, little-endian
    step(1, 2'd2, 32'h44332211, 0, 2'd0, 0, 0);
    step(0, 2'd0, 0, 1, 2'd0, 0, 0);
    chk(cap_data == 32'h11, "R5 byte", cap_data, 32'h11);
    step(0, 2'd0, 0, 1, 2'd1, 0, 0);
    chk(cap_data == 32'h3322, "R5 half", cap_data, 32'h3322);
    // R7: one byte left, word asked under flush
    step(0, 2'd0, 0, 1, 2'd2, 1, 0);
    chk(cap_rval && cap_cnt == 3'd1 && cap_data == 32'h44, "R7 remainder", cap_data, 32'h44);

    // R6: big-endian
    step(1, 2'd2, 32'hA1B2C3D4, 0, 2'd0, 0, 1);
    step(0, 2'd0, 0, 1, 2'd1, 0, 1);
    chk(cap_data == 32'hA1B2, "R6 half", cap_data, 32'hA1B2);
    // R8: select flips while data is held; order stays big-endian
    step(0, 2'd0, 0, 1, 2'd1, 0, 0);
    chk(cap_data == 32'hC3D4, "R8 held order", cap_data, 32'hC3D4);
    step(1, 2'd1, 32'h5566, 0, 2'd0, 0, 0);
    step(0, 2'd0, 0, 1, 2'd0, 0, 0);
    chk(cap_data == 32'h66, "R8 new order when empty", cap_data, 32'h66);
    step(0, 2'd0, 0, 1, 2'd0, 0, 0);

    // R10: upper write lanes ignored
    step(1, 2'd0, 32'hFFFFFF5A, 0, 2'd0, 0, 0);
    step(0, 2'd0, 0, 1, 2'd2, 1, 0);
    chk(cap_data == 32'h5A, "R10 lanes", cap_data, 32'h5A);

    // R3: fill to capacity, then a byte is refused
    for (int i = 0; i < 4; i++) step(1, 2'd2, 32'h01020304 * (i + 1), 0, 2'd0, 0, 0);
    step(1, 2'd0, 32'h77, 0, 2'd0, 0, 0);
    chk(!cap_wrdy && cap_lvl == 5'd16, "R3 full", {27'd0, cap_lvl}, 32'd16);
    // R9: simultaneous write and read
    for (int i = 0; i < 3; i++) step(0, 2'd0, 0, 1, 2'd2, 0, 0);
    step(1, 2'd2, 32'hCAFEF00D, 1, 2'd2, 0, 0);
    step(0, 2'd0, 0, 0, 2'd0, 0, 0);
    chk(cap_lvl == 5'd4, "R9 same cycle", {27'd0, cap_lvl}, 32'd4);

    // Random traffic (R2: sizes from the defined codes only)
    for (int i = 0; i < 3000; i++) begin
      logic b;
      b = ($urandom % 20 == 0) ? ~endian_be : endian_be;
      step(($urandom % 10) < 6, 2'($urandom % 3), $urandom,
           ($urandom % 10) < 6, 2'($urandom % 3), ($urandom % 10) == 0, b);
    end
    // Drain
    for (int i = 0; i < 20; i++) step(0, 2'd0, 0, 1, 2'd2, 1, endian_be);
    chk(q.size() == 0 && level == 5'd0, "R7 drained", {27'd0, level}, 32'd0);

    done = 1;
    finish_run();
  end

endmodule